// File: doc/BRIEF.md
# Supply Supervisor with Reset Stretch

This block turns three digitized supply-comparator flags into the control signals for a battery-backed memory and its host processor. The three flags say whether the supply is above the operating threshold, above the lower write-protect threshold, and above the battery switchover level. Each flag is resynchronized and debounced before use. From the cleaned flags the block produces four outputs:

- a memory write-protect;
- a storage power-source select (battery or external supply);
- a drive-low enable for an open-drain reset line toward the host;
- a one-cycle power-good strobe that a battery test sequencer can use as its start trigger.

The block holds the host in reset for a fixed stretch after the supply becomes fully good, and restarts the stretch if the supply drops out before it completes. Between the two thresholds it applies hysteresis. A supply that sinks below the operating level warns the host by asserting reset, but stores are still allowed until the supply reaches the write-protect level. Timer lengths are parameters, so the block can be simulated at a reduced scale.

Top module: `supply_supervisor`

## Requirements
- R1: Each comparator flag passes through a two-flop synchronizer and a filter. The filtered value changes only after the synchronized flag has differed from it for FILT_LEN consecutive cycles. A flag excursion of FILT_LEN-1 cycles or fewer has no effect on any output. An excursion held long enough reaches the outputs on the (FILT_LEN+3)-th rising edge after the input changes.
- R2: After a synchronous reset, outputs are: write-protect 1, reset drive-low enable 1, battery select 1, power-good strobe 0.
- R3: The supply counts as fully good only when all three flags are 1. After it becomes fully good, the reset drive-low enable falls on the (FILT_LEN+STRETCH_LEN+3)-th rising edge after the flags rise.
- R4: During the stretch, write-protect stays 1. It falls on the same edge on which reset is released.
- R5: The power-good strobe is 1 for exactly one cycle, coinciding with the first cycle of reset release. It never occurs at any other time.
- R6: If the fully-good condition is lost before the stretch completes, the stretch counter restarts. The next power-up again takes the full R3 latency and produces no strobe before it.
- R7: In normal operation, a drop of only the operating flag, with write-protect and switchover flags still 1, asserts the reset drive-low enable while write-protect stays 0.
- R8: A drop of the write-protect flag or the switchover flag in any state sets write-protect to 1 and the reset drive-low enable to 1.
- R9: The battery select output (1 = storage powered from battery) equals the inverse of the filtered switchover flag, with the R1 latency.
- R10: When the operating flag returns in the warning state of R7, the block runs a fresh protected stretch with the R3 latency and emits a new strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| above_op_i | input | 1 | Supply above operating threshold (asynchronous) |
| above_wp_i | input | 1 | Supply above write-protect threshold (asynchronous) |
| above_sw_i | input | 1 | Supply above battery switchover level (asynchronous) |
| wr_protect_o | output | 1 | 1 = memory stores blocked |
| on_battery_o | output | 1 | 1 = storage powered from battery |
| host_rst_pull_o | output | 1 | 1 = pull the open-drain host reset low, 0 = release |
| pgood_pulse_o | output | 1 | One-cycle strobe when the reset stretch ends |

## Verification
The embedded assertions check several rules on every cycle:
- the filtered flag changes only after a disagreement with the synchronized input;
- the stretch counter stays in range;
- the strobe coincides with a reset release;
- write-protect is lifted only together with reset release;
- reset is never released while the supply is not fully good.

Other behaviours can only be shown by the bench's scenarios: the exact power-up latency, rejection of short glitches, the restart of an interrupted stretch, the hysteresis band and a full sweep of all eight flag combinations from normal operation.

// File: rtl/supsup_pkg.sv
package supsup_pkg;
  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_STRETCH = 2'd1,
    ST_RUN     = 2'd2,
    ST_WARN    = 2'd3
  } sup_state_t;

  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned IDX_OP = 0;
  localparam int unsigned IDX_WP = 1;
  localparam int unsigned IDX_SW = 2;
endpackage

// File: rtl/flag_filter.sv
module flag_filter #(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= d_i;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      q_o <= 1'b0;
    end else if (s2 != q_o) begin
      if (cnt == CW'(FILT_LEN - 1)) begin
        cnt <= '0;
        q_o <= s2;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

  // R1
  filt_follows_input_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(q_o) |-> $past(s2 != q_o));

  // R1
  filt_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(FILT_LEN));
endmodule

// File: rtl/power_ctrl.sv
module power_ctrl
  import supsup_pkg::*;
#(
  parameter int unsigned STRETCH_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic op_ok_i,
  input  logic wp_ok_i,
  input  logic sw_ok_i,
  output logic wr_protect_o,
  output logic on_battery_o,
  output logic rst_pull_o,
  output logic pgood_o
);
  localparam int unsigned CW = $clog2(STRETCH_LEN + 1);

  sup_state_t    st, nxt;
  logic [CW-1:0] cnt;
  logic          good, done;

  assign good = op_ok_i & wp_ok_i & sw_ok_i;

  always_comb begin
    nxt  = st;
    done = 1'b0;
    unique case (st)
      ST_OFF:
        if (good) nxt = ST_STRETCH;
      ST_STRETCH:
        if (!good) nxt = ST_OFF;
        else if (cnt == CW'(STRETCH_LEN - 1)) begin
          nxt  = ST_RUN;
          done = 1'b1;
        end
      ST_RUN:
        if (!wp_ok_i || !sw_ok_i) nxt = ST_OFF;
        else if (!op_ok_i) nxt = ST_WARN;
      ST_WARN:
        if (!wp_ok_i || !sw_ok_i) nxt = ST_OFF;
        else if (op_ok_i) nxt = ST_STRETCH;
      default: nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_OFF;
      cnt <= '0;
    end else begin
      st  <= nxt;
      cnt <= (st == ST_STRETCH && nxt == ST_STRETCH) ? cnt + 1'b1 : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_protect_o <= 1'b1;
      rst_pull_o   <= 1'b1;
      on_battery_o <= 1'b1;
      pgood_o      <= 1'b0;
    end else begin
      wr_protect_o <= !(nxt == ST_RUN || nxt == ST_WARN);
      rst_pull_o   <= (nxt != ST_RUN);
      on_battery_o <= !sw_ok_i;
      pgood_o      <= done;
    end
  end

  // R3
  stretch_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(STRETCH_LEN));

  // R5
  pgood_at_release_chk: assert property (@(posedge clk) disable iff (rst)
    pgood_o |-> (!rst_pull_o && $past(rst_pull_o)));

  // R4
  unprotect_with_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_protect_o) |-> ($fell(rst_pull_o) && pgood_o));

  // R3
  release_needs_good_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_pull_o) |-> $past(good));

  // R8
  run_means_writable_chk: assert property (@(posedge clk) disable iff (rst)
    !rst_pull_o |-> !wr_protect_o);
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import supsup_pkg::*;
#(
  parameter int unsigned FILT_LEN    = 4,
  parameter int unsigned STRETCH_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic above_op_i,
  input  logic above_wp_i,
  input  logic above_sw_i,
  output logic wr_protect_o,
  output logic on_battery_o,
  output logic host_rst_pull_o,
  output logic pgood_pulse_o
);
  logic [NUM_FLAGS-1:0] raw, filt;

  assign raw[IDX_OP] = above_op_i;
  assign raw[IDX_WP] = above_wp_i;
  assign raw[IDX_SW] = above_sw_i;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flt
    flag_filter #(.FILT_LEN(FILT_LEN)) u_flt (
      .clk (clk),
      .rst (rst),
      .d_i (raw[g]),
      .q_o (filt[g])
    );
  end

  power_ctrl #(.STRETCH_LEN(STRETCH_LEN)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .op_ok_i      (filt[IDX_OP]),
    .wp_ok_i      (filt[IDX_WP]),
    .sw_ok_i      (filt[IDX_SW]),
    .wr_protect_o (wr_protect_o),
    .on_battery_o (on_battery_o),
    .rst_pull_o   (host_rst_pull_o),
    .pgood_o      (pgood_pulse_o)
  );
endmodule

// File: tb/tb_supply_supervisor.sv
module tb_supply_supervisor;
  localparam int F = 3;
  localparam int L = 20;
  localparam int UP_LAT = F + L + 3;
  localparam int DN_LAT = F + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op = 1'b0, wp = 1'b0, sw = 1'b0;
  logic wprot, batt, rpull, pg;
  int checks = 0, failures = 0, pulses = 0;

  always #10 clk = ~clk;

  supply_supervisor #(.FILT_LEN(F), .STRETCH_LEN(L)) dut (
    .clk(clk), .rst(rst), .above_op_i(op), .above_wp_i(wp), .above_sw_i(sw),
    .wr_protect_o(wprot), .on_battery_o(batt), .host_rst_pull_o(rpull),
    .pgood_pulse_o(pg)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (pg) pulses++;
  endtask

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic go_off();
    op = 0; wp = 0; sw = 0;
    wait_n(F + 6);
  endtask

  // drive all flags high, measure edges until reset release
  task automatic power_up(string req);
    int n = 0;
    int p0 = pulses;
    op = 1; wp = 1; sw = 1;
    while (rpull && n < 500) begin
      tick();
      n++;
      if (n == F + 4) chk({req, " R4 protected during stretch"}, wprot, 1);
    end
    chk({req, " release latency"}, n, UP_LAT);
    chk({req, " R4 wprot low at release"}, wprot, 0);
    chk({req, " R5 strobe at release"}, pg, 1);
    chk({req, " R5 single strobe count"}, pulses - p0, 1);
    tick();
    chk({req, " R5 strobe one cycle"}, pg, 0);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int p0;
    int e_prot, e_rst;
    @(negedge clk);
    wait_n(3);
    rst = 0;
    // R2 reset state
    chk("R2 wprot", wprot, 1);
    chk("R2 rst_pull", rpull, 1);
    chk("R2 battery", batt, 1);
    chk("R2 pgood", pg, 0);

    // R3 power-up
    power_up("R3");

    // R1 glitch on wp of F-1 cycles ignored
    wp = 0; wait_n(F - 1); wp = 1;
    wait_n(F + 6);
    chk("R1 glitch wprot", wprot, 0);
    chk("R1 glitch rst_pull", rpull, 0);

    // R1 R8 long drop of wp, exact latency
    wp = 0;
    wait_n(DN_LAT - 1);
    chk("R1 before latency wprot", wprot, 0);
    tick();
    chk("R1 R8 wprot at latency", wprot, 1);
    chk("R8 rst_pull", rpull, 1);

    // R6 interrupted stretch
    go_off();
    op = 1; wp = 1; sw = 1;
    p0 = pulses;
    wait_n(F + 2 + L / 2);
    op = 0;
    wait_n(F + L + 6);
    chk("R6 no strobe on abort", pulses - p0, 0);
    chk("R6 still reset", rpull, 1);
    power_up("R6");

    // R7 hysteresis then R10 recovery
    op = 0;
    wait_n(F + 6);
    chk("R7 rst asserted", rpull, 1);
    chk("R7 still writable", wprot, 0);
    power_up("R10");

    // R9 switchover latency
    sw = 0;
    wait_n(DN_LAT - 1);
    chk("R9 before latency", batt, 0);
    tick();
    chk("R9 battery select", batt, 1);
    chk("R8 sw drop protects", wprot, 1);

    // sweep all flag combinations from normal operation
    for (int c = 0; c < 8; c++) begin
      go_off();
      power_up("R3 sweep");
      op = c[0]; wp = c[1]; sw = c[2];
      wait_n(F + L + 10);
      if (c == 7) begin e_prot = 0; e_rst = 0; end
      else if (!c[1] || !c[2]) begin e_prot = 1; e_rst = 1; end
      else begin e_prot = 0; e_rst = 1; end
      chk("R8 R7 sweep wprot", wprot, e_prot);
      chk("R8 R7 sweep rst_pull", rpull, e_rst);
      chk("R9 sweep battery", batt, c[2] ? 0 : 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule